// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front-End

This block is the slave end of a two-wire serial memory link. It samples the clock and data lines with the system clock, recognises bus start and stop conditions, receives 8-bit words most significant bit first, and acknowledges each accepted word by pulling the data line low during the ninth clock. Every accepted write byte is handed to the memory core on a one-cycle strobe. For reads, it takes bytes from a simple byte input and shifts them onto the line. The master's acknowledge decides whether another byte follows.

When a write transaction ends with a stop, an internal write-cycle timer starts. While that timer runs, the block stays busy and does not acknowledge its own address, so a master can poll for completion. The block reports standby only when no transfer is open and the timer is idle.

Top module: `tw_slave_frontend`

## Requirements
- R1: After reset, standby_o is 1, busy_o is 0, sda_pull_o is 0 and rx_valid_o is 0.
- R2: After a start condition, the first byte is the 7-bit device address followed by a direction bit (1 = read, 0 = write). The block acknowledges only when the address equals DEV_ADDR and busy_o is 0. After an address that is not acknowledged, every byte is ignored until the next start: there is no acknowledge and no rx_valid_o.
- R3: In a write transfer, each data byte is received MSB first, sampled on rising SCL. It appears on rx_data_o with a single-cycle rx_valid_o pulse and is acknowledged in the ninth clock.
- R4: An SDA change while SCL is high is a start condition (falling) or a stop condition (rising), never data. A start in the middle of a byte discards the partial byte and restarts address reception.
- R5: In a read transfer, the byte on rd_data_i is latched with a one-cycle rd_take_o pulse and driven MSB first. A master acknowledge (SDA low in the ninth clock) loads the next byte. A not-acknowledge (SDA high) makes the block release SDA and go idle.
- R6: A stop that closes a transaction in which at least one write data byte was received holds busy_o high for exactly WR_CYCLES system clock cycles. A stop after only an address, or after a read, does not set busy_o.
- R7: While busy_o is high, the block never pulls SDA low, so its own address goes unacknowledged.
- R8: standby_o is 0 from shortly after an accepted start until the transfer ends. It returns to 1 only when the transfer has ended and busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain drive) |
| rx_valid_o | output | 1 | One-cycle strobe: a write data byte is on rx_data_o |
| rx_data_o | output | 8 | Last received write data byte |
| rd_data_i | input | 8 | Next byte to transmit in a read |
| rd_take_o | output | 1 | One-cycle strobe: rd_data_i has been latched for sending |
| busy_o | output | 1 | Internal write cycle in progress |
| standby_o | output | 1 | No transfer open and no write cycle pending |

## Verification
The functions most likely to collide are the end of a write, which starts the write timer, and a new address phase that arrives straight after it. The bench provokes this by issuing a fresh start and the block's own address right after the stop that closes a 256-byte write. It then judges the result at the ports: the address must get no acknowledge and SDA must never be pulled. The busy interval, counted cycle by cycle, must still equal the configured length exactly. A second collision is a start arriving mid-byte. The bench sends it during both an address byte and a data byte, and checks that no stray byte strobe appears and that the next address is accepted cleanly.

// File: rtl/tw_pkg.sv
// Shared definitions for the two-wire slave front-end.
// Assumes 8-bit words plus one acknowledge clock per word.
package tw_pkg;

    localparam int unsigned WORD_W = 8;

    // Bit counter codes: 0..7 data bits counted, 8 = word complete, 9 = in ack clock.
    localparam logic [3:0] CNT_FULL = 4'd8;
    localparam logic [3:0] CNT_ACK  = 4'd9;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_WRITE = 2'd2,
        PH_READ  = 2'd3
    } tw_phase_e;

endpackage

// File: rtl/tw_line_sync.sv
// Brings SCL and SDA into the clock domain through a synchronizer chain and
// derives rising/falling SCL and start/stop events.
// Assumes STAGES >= 2 and that both lines idle high (pipelines reset to 1).
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_last;
    logic              sda_last;
    logic              scl_now;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_last <= 1'b1;
            sda_last <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_last <= scl_pipe[STAGES-1];
            sda_last <= sda_pipe[STAGES-1];
        end
    end

    assign scl_now    = scl_pipe[STAGES-1];
    assign sda_o      = sda_pipe[STAGES-1];
    assign scl_rise_o = scl_now & ~scl_last;
    assign scl_fall_o = ~scl_now & scl_last;
    assign start_o    = scl_now & scl_last & sda_last & ~sda_o;
    assign stop_o     = scl_now & scl_last & ~sda_last & sda_o;

endmodule

// File: rtl/tw_byte_engine.sv
// Word-level protocol engine: address match, write byte reception, read byte
// transmission, acknowledge handling and write-commit signalling.
// Assumes single-cycle event strobes from tw_line_sync. SDA is sampled on SCL
// rise and driven on SCL fall.
module tw_byte_engine
    import tw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic              busy_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              sda_low_o,
    output logic              rx_valid_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rd_take_o,
    output logic              commit_o,
    output logic              idle_o
);

    tw_phase_e         phase;
    logic [3:0]        bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] tx_byte;
    logic              dir_rd;
    logic              wrote;

    // Protocol sequencer; start/stop outrank clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            tx_byte    <= '0;
            dir_rd     <= 1'b0;
            wrote      <= 1'b0;
            sda_low_o  <= 1'b0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
            rd_take_o  <= 1'b0;
            commit_o   <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            rd_take_o  <= 1'b0;
            commit_o   <= 1'b0;
            if (start_i) begin
                phase     <= PH_ADDR;
                bit_cnt   <= '0;
                sda_low_o <= 1'b0;
            end else if (stop_i) begin
                phase     <= PH_IDLE;
                bit_cnt   <= '0;
                sda_low_o <= 1'b0;
                commit_o  <= wrote;
                wrote     <= 1'b0;
            end else if (scl_rise_i) begin
                case (phase)
                    PH_ADDR, PH_WRITE: begin
                        if (bit_cnt < CNT_FULL) begin
                            shreg   <= {shreg[WORD_W-2:0], sda_i};
                            bit_cnt <= bit_cnt + 4'd1;
                            if (phase == PH_WRITE && bit_cnt == 4'd7) begin
                                rx_valid_o <= 1'b1;
                                rx_data_o  <= {shreg[WORD_W-2:0], sda_i};
                                wrote      <= 1'b1;
                            end
                        end
                    end
                    PH_READ: begin
                        if (bit_cnt < CNT_FULL) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (bit_cnt == CNT_ACK && sda_i) begin
                            phase   <= PH_IDLE;
                            bit_cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end else if (scl_fall_i) begin
                case (phase)
                    PH_ADDR: begin
                        if (bit_cnt == CNT_FULL) begin
                            if (shreg[WORD_W-1:1] == DEV_ADDR && !busy_i) begin
                                sda_low_o <= 1'b1;
                                dir_rd    <= shreg[0];
                                bit_cnt   <= CNT_ACK;
                            end else begin
                                phase   <= PH_IDLE;
                                bit_cnt <= '0;
                            end
                        end else if (bit_cnt == CNT_ACK) begin
                            bit_cnt <= '0;
                            if (dir_rd) begin
                                phase     <= PH_READ;
                                tx_byte   <= rd_data_i;
                                sda_low_o <= ~rd_data_i[WORD_W-1];
                                rd_take_o <= 1'b1;
                            end else begin
                                phase     <= PH_WRITE;
                                sda_low_o <= 1'b0;
                            end
                        end
                    end
                    PH_WRITE: begin
                        if (bit_cnt == CNT_FULL) begin
                            sda_low_o <= 1'b1;
                            bit_cnt   <= CNT_ACK;
                        end else if (bit_cnt == CNT_ACK) begin
                            sda_low_o <= 1'b0;
                            bit_cnt   <= '0;
                        end
                    end
                    PH_READ: begin
                        if (bit_cnt == CNT_FULL) begin
                            sda_low_o <= 1'b0;
                            bit_cnt   <= CNT_ACK;
                        end else if (bit_cnt == CNT_ACK) begin
                            tx_byte   <= rd_data_i;
                            sda_low_o <= ~rd_data_i[WORD_W-1];
                            rd_take_o <= 1'b1;
                            bit_cnt   <= '0;
                        end else if (bit_cnt != 4'd0) begin
                            sda_low_o <= ~tx_byte[3'd7 - bit_cnt[2:0]];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign idle_o = (phase == PH_IDLE);

endmodule

// File: rtl/tw_write_timer.sv
// Internal write-cycle timer: a commit pulse loads CYCLES, and busy_o stays
// high until the count drains. Assumes CYCLES >= 1.
module tw_write_timer #(
    parameter int CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    // Load on commit, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (launch_i) begin
            remain <= CW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign busy_o = (remain != '0);

endmodule

// File: rtl/tw_slave_frontend.sv
// Top of the two-wire serial memory slave front-end. It joins the line
// synchronizer, the protocol engine and the write-cycle timer.
// Assumes an open-drain pad: sda_pull_o = 1 pulls the line low externally.
module tw_slave_frontend #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         WR_CYCLES   = 1250000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    input  logic [7:0] rd_data_i,
    output logic       rd_take_o,
    output logic       busy_o,
    output logic       standby_o
);

    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_ev;
    logic stop_ev;
    logic commit;
    logic idle;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    tw_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .sda_i      (sda_s),
        .busy_i     (busy_o),
        .rd_data_i  (rd_data_i),
        .sda_low_o  (sda_pull_o),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o),
        .rd_take_o  (rd_take_o),
        .commit_o   (commit),
        .idle_o     (idle)
    );

    tw_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (commit),
        .busy_o   (busy_o)
    );

    assign standby_o = idle & ~busy_o;

endmodule

// File: rtl/tw_slave_checker.sv
// Port-level properties of tw_slave_frontend, attached by bind.
// Assumes the master changes SDA only while SCL is low.
module tw_slave_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_pull_o,
    input logic rx_valid_o,
    input logic rd_take_o,
    input logic busy_o,
    input logic standby_o
);

    // R7: no acknowledge or data drive during the write cycle.
    p_no_pull_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_pull_o);

    // R8: a block in standby leaves the line alone.
    p_no_pull_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> !sda_pull_o);

    // R3: the write byte strobe lasts one cycle.
    p_rx_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R5: the read byte take strobe lasts one cycle.
    p_take_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take_o |=> !rd_take_o);

    // R4: the slave's own drive never changes while SCL is high.
    p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);

endmodule

bind tw_slave_frontend tw_slave_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .rx_valid_o (rx_valid_o),
    .rd_take_o  (rd_take_o),
    .busy_o     (busy_o),
    .standby_o  (standby_o)
);

// File: tb/test_tw_slave_frontend.sv
module test_tw_slave_frontend;

    localparam logic [6:0] DEV = 7'h50;
    localparam int WRC = 400;
    localparam int H = 8;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull_o, rx_valid_o, rd_take_o, busy_o, standby_o;
    logic [7:0] rx_data_o, rd_data;

    int n_chk = 0, n_fail = 0;
    int rx_cnt = 0, take_cnt = 0, busy_cnt = 0, rd_idx = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_o;
    assign rd_data  = 8'((rd_idx * 37 + 11) & 255);

    tw_slave_frontend #(.DEV_ADDR(DEV), .WR_CYCLES(WRC)) i_tw_slave_frontend (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
        .rd_data_i(rd_data), .rd_take_o(rd_take_o), .busy_o(busy_o),
        .standby_o(standby_o)
    );

    // Observers sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_valid_o) begin rx_cnt++; rx_last = rx_data_o; end
        if (rd_take_o) begin take_cnt++; rd_idx++; end
        if (busy_o) busy_cnt++;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop();
        wait_cyc(Q); sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b1; wait_cyc(H);
    endtask

    task automatic put_bit(input logic b);
        wait_cyc(Q); sda_m = b; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(H);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wait_cyc(Q); sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(H / 2);
        b = sda_line; wait_cyc(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(~ack);
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] v;
        int base;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        // R1 reset state
        check("R1 standby", int'(standby_o), 1);
        check("R1 busy", int'(busy_o), 0);
        check("R1 pull", int'(sda_pull_o), 0);
        check("R1 rx_valid", int'(rx_valid_o), 0);

        // R2 address sweep: only DEV acked; address-only gives no busy (R6)
        for (int a = 0; a < 128; a++) begin
            bus_start();
            put_byte({7'(a), 1'b0}, ak);
            check("R2 addr ack", int'(ak), (a == int'(DEV)) ? 1 : 0);
            bus_stop();
            wait_cyc(4);
        end
        check("R6 no busy after address only", busy_cnt, 0);

        // R2 bytes after a foreign address are ignored
        base = rx_cnt;
        bus_start();
        put_byte({7'h51, 1'b0}, ak);
        check("R2 foreign addr nack", int'(ak), 0);
        put_byte(8'hA5, ak);
        check("R2 ignored byte nack", int'(ak), 0);
        check("R2 ignored byte no strobe", rx_cnt, base);
        bus_stop();
        wait_cyc(4);
        check("R6 no busy after foreign", busy_cnt, 0);

        // R3 write sweep of all byte values
        bus_start();
        put_byte({DEV, 1'b0}, ak);
        check("R2 write addr ack", int'(ak), 1);
        check("R8 standby low in transfer", int'(standby_o), 0);
        base = rx_cnt;
        for (int d = 0; d < 256; d++) begin
            put_byte(8'(d), ak);
            check("R3 data ack", int'(ak), 1);
            check("R3 data value", int'(rx_last), d);
        end
        check("R3 strobe count", rx_cnt - base, 256);
        bus_stop();
        // R7 poll straight after the stop: busy, so no ack
        bus_start();
        check("R7 busy during poll", int'(busy_o), 1);
        put_byte({DEV, 1'b0}, ak);
        check("R7 poll nack", int'(ak), 0);
        bus_stop();
        check("R8 standby low while busy", int'(standby_o), 0);
        for (int i = 0; i < 2000 && busy_o; i++) wait_cyc(1);
        wait_cyc(2);
        check("R6 busy length", busy_cnt, WRC);
        check("R8 standby after write cycle", int'(standby_o), 1);

        // R4 start in the middle of an address byte
        base = rx_cnt;
        bus_start();
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        put_byte({DEV, 1'b0}, ak);
        check("R4 addr after restart ack", int'(ak), 1);
        put_byte(8'h3C, ak);
        check("R4 data after restart", int'(rx_last), 8'h3C);
        // R4 start in the middle of a data byte: partial byte dropped
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        bus_start();
        check("R4 partial byte dropped", rx_cnt - base, 1);
        put_byte({DEV, 1'b0}, ak);
        check("R4 addr after data abort ack", int'(ak), 1);
        bus_stop();
        wait_cyc(10);
        check("R6 busy after restarted write", int'(busy_o), 1);
        for (int i = 0; i < 2000 && busy_o; i++) wait_cyc(1);
        wait_cyc(2);
        check("R6 second busy length", busy_cnt, 2 * WRC);

        // R5 read sweep, ACK on all but the last byte
        rd_idx = 0;
        take_cnt = 0;
        bus_start();
        put_byte({DEV, 1'b1}, ak);
        check("R5 read addr ack", int'(ak), 1);
        for (int k = 0; k < 256; k++) begin
            get_byte(k != 255, v);
            check("R5 read value", int'(v), (k * 37 + 11) & 255);
        end
        wait_cyc(Q);
        check("R5 released after nack", int'(sda_pull_o), 0);
        check("R5 take count", take_cnt, 256);
        bus_stop();
        wait_cyc(10);
        check("R6 no busy after read", busy_cnt, 2 * WRC);
        check("R8 standby after read", int'(standby_o), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule